// File: doc/BRIEF.md
# Static Memory Wait-State Sequencer

This block runs single read and write accesses to one region of external asynchronous static memory, such as SRAM or NOR flash. An internal requester gives it an address, write data, a direction bit and a byte-lane mask. The block then drives the chip select, the output enable, the write enable, the per-byte lane enables, the address bus and a data bus split into in, out and drive-enable. A one-clock done pulse ends each access. For reads, the captured data is presented alongside that pulse.

Each direction has its own wait count, supplied on configuration inputs that stay stable during an access. Every wait state is one clock long, and the cycle in which the strobe first asserts is the first one. The external device can lengthen the strobe phase through an active-low wait input, which is sampled on every clock. A write always places one setup cycle with chip select low ahead of the write strobe. It also keeps chip select, address and data for one cycle after the strobe. As a result the shortest read takes 2 clocks and the shortest write takes 3.

Top module: `sram_wait_seq`

## Requirements
- R1: Under reset, chip select, output enable, write enable and every lane enable are high (inactive). The data bus is not driven, done is low and reqReady is high.
- R2: A read with wait count 0 and the wait input high holds chip select and output enable low for exactly one clock. The next cycle has chip select high, the same address held and done high, so the read takes 2 clocks.
- R3: A read with wait count N keeps output enable low for N+1 clocks. The data on memDataIn is captured on the edge that ends that phase.
- R4: On a write, chip select falls on the same edge that presents the address, and the data bus is driven from that cycle on. Write enable falls exactly one clock later.
- R5: A write with wait count N holds write enable low for N+1 clocks, so the write takes N+3 clocks.
- R6: After write enable rises, chip select, address and driven data stay unchanged for one more clock, and done is high in that clock. The address never changes while chip select stays low.
- R7: Lane enable bit i follows write enable exactly when bit i of reqLanes was set at acceptance, with bit 0 covering data bits 7:0. Otherwise the bit stays high, and all lane enables stay high during reads and idle.
- R8: A strobe phase ends only at the first clock edge where the programmed count is used up and memWaitN samples high. A low wait during the programmed count has no effect, and each low sample after the count adds one clock.
- R9: done is high for exactly one clock per access. After a read, rdData holds the captured word from that pulse until the next read capture.
- R10: A request is taken only while reqReady is high, which is exactly when no access is in progress. Requests raised during an access start no extra access.
- R11: memDataOe is high only from the write's chip-select cycle through its hold cycle. It is never high while output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqLanes | input | DATA_W/8 | Byte-lane select for writes, bit i = byte i |
| cfgRdWait | input | WAIT_W | Read wait count |
| cfgWrWait | input | WAIT_W | Write wait count |
| reqReady | output | 1 | Idle, able to take a request |
| done | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Captured read data |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memLaneN | output | DATA_W/8 | Byte-lane enables, active low |
| memAddr | output | ADDR_W | Address bus |
| memDataOut | output | DATA_W | Data driven toward memory |
| memDataOe | output | 1 | Data bus drive enable |
| memDataIn | input | DATA_W | Data returned from memory |
| memWaitN | input | 1 | External wait, active low |

## Verification
The bench targets four timing risks:
- **Write setup cycle.** If it is dropped, write enable falls together with chip select and the measured setup count is zero.
- **Hold cycle.** If it is lost, chip select or the address is released with the strobe and the write takes one clock too few.
- **Wait input.** Wait is held low both inside and past the programmed count. A design that adds wait cycles to the count, or ignores the wait input, gives a strobe of the wrong length.
- **Busy period.** Requests are held asserted throughout an access. A design that takes one while busy produces an access the scoreboard never expected.

Lane masks with only one bit set catch lanes that are wired to the full write enable.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STROBE,
    ST_RD_HOLD,
    ST_WR_SETUP,
    ST_WR_STROBE,
    ST_WR_HOLD
  } seq_state_e;

  // Strobes from control to datapath. The *Next fields give the pin
  // levels for the coming cycle; load and capture act on this edge.
  typedef struct packed {
    logic load;
    logic capture;
    logic csNext;
    logic oeNext;
    logic weNext;
    logic driveNext;
  } seq_ctrl_t;

endpackage

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [WAIT_W-1:0] cfgRdWait,
  input  logic [WAIT_W-1:0] cfgWrWait,
  input  logic              memWaitN,
  output seq_ctrl_t         ctrl,
  output logic              ready,
  output logic              doneOut
);

  seq_state_e        state, stateNext;
  logic [WAIT_W-1:0] waitCnt, waitCntNext;
  logic              accept;
  logic              strobeEnd;
  logic              inStrobe;

  assign accept    = (state == ST_IDLE) && reqValid;
  assign inStrobe  = (state == ST_RD_STROBE) || (state == ST_WR_STROBE);
  // Phase ends once the count is spent and the device is not stalling.
  assign strobeEnd = (waitCnt == '0) && memWaitN;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:      if (reqValid) stateNext = reqWrite ? ST_WR_SETUP : ST_RD_STROBE;
      ST_RD_STROBE: if (strobeEnd) stateNext = ST_RD_HOLD;
      ST_RD_HOLD:   stateNext = ST_IDLE;
      ST_WR_SETUP:  stateNext = ST_WR_STROBE;
      ST_WR_STROBE: if (strobeEnd) stateNext = ST_WR_HOLD;
      ST_WR_HOLD:   stateNext = ST_IDLE;
      default:      stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    waitCntNext = waitCnt;
    if (accept) begin
      waitCntNext = reqWrite ? '0 : cfgRdWait;
    end else if (state == ST_WR_SETUP) begin
      waitCntNext = cfgWrWait;
    end else if (inStrobe && (waitCnt != '0)) begin
      waitCntNext = waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
    end else begin
      state   <= stateNext;
      waitCnt <= waitCntNext;
    end
  end

  always_comb begin
    ctrl.load      = accept;
    ctrl.capture   = (state == ST_RD_STROBE) && strobeEnd;
    ctrl.csNext    = (stateNext == ST_RD_STROBE) || (stateNext == ST_WR_SETUP) ||
                     (stateNext == ST_WR_STROBE) || (stateNext == ST_WR_HOLD);
    ctrl.oeNext    = (stateNext == ST_RD_STROBE);
    ctrl.weNext    = (stateNext == ST_WR_STROBE);
    ctrl.driveNext = (stateNext == ST_WR_SETUP) || (stateNext == ST_WR_STROBE) ||
                     (stateNext == ST_WR_HOLD);
  end

  assign ready   = (state == ST_IDLE);
  assign doneOut = (state == ST_RD_HOLD) || (state == ST_WR_HOLD);

endmodule

// File: rtl/sram_seq_datapath.sv
module sram_seq_datapath
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seq_ctrl_t         ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLanes,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] rdData
);

  logic [LANES-1:0] laneSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr    <= '0;
      memDataOut <= '0;
      laneSel    <= '0;
    end else if (ctrl.load) begin
      memAddr    <= reqAddr;
      memDataOut <= reqWdata;
      laneSel    <= reqLanes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctrl.capture) begin
      rdData <= memDataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCsN    <= 1'b1;
      memOeN    <= 1'b1;
      memWeN    <= 1'b1;
      memDataOe <= 1'b0;
    end else begin
      memCsN    <= ~ctrl.csNext;
      memOeN    <= ~ctrl.oeNext;
      memWeN    <= ~ctrl.weNext;
      memDataOe <= ctrl.driveNext;
    end
  end

  // One flop per lane; laneSel was loaded at acceptance, before any strobe.
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memLaneN[i] <= 1'b1;
      end else if (ctrl.load) begin
        memLaneN[i] <= 1'b1;
      end else begin
        memLaneN[i] <= ~(ctrl.weNext & laneSel[i]);
      end
    end
  end

endmodule

// File: rtl/sram_wait_seq.sv
module sram_wait_seq
  import sram_seq_pkg::*;
#(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 16,
  parameter int  WAIT_W = 4,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqLanes,
  input  logic [WAIT_W-1:0] cfgRdWait,
  input  logic [WAIT_W-1:0] cfgWrWait,
  output logic              reqReady,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [LANES-1:0]  memLaneN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn,
  input  logic              memWaitN
);

  seq_ctrl_t ctrl;

  sram_seq_ctrl #(.WAIT_W(WAIT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .cfgRdWait (cfgRdWait),
    .cfgWrWait (cfgWrWait),
    .memWaitN  (memWaitN),
    .ctrl      (ctrl),
    .ready     (reqReady),
    .doneOut   (done)
  );

  sram_seq_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqLanes   (reqLanes),
    .memDataIn  (memDataIn),
    .memAddr    (memAddr),
    .memDataOut (memDataOut),
    .memDataOe  (memDataOe),
    .memCsN     (memCsN),
    .memOeN     (memOeN),
    .memWeN     (memWeN),
    .memLaneN   (memLaneN),
    .rdData     (rdData)
  );

endmodule

// File: rtl/sram_wait_seq_chk.sv
module sram_wait_seq_chk #(
  parameter int  ADDR_W = 16,
  parameter int  DATA_W = 16,
  parameter int  WAIT_W = 4,
  localparam int LANES  = DATA_W / 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] reqWdata,
  input logic [LANES-1:0]  reqLanes,
  input logic [WAIT_W-1:0] cfgRdWait,
  input logic [WAIT_W-1:0] cfgWrWait,
  input logic              reqReady,
  input logic              done,
  input logic [DATA_W-1:0] rdData,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [LANES-1:0]  memLaneN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDataOut,
  input logic              memDataOe,
  input logic [DATA_W-1:0] memDataIn,
  input logic              memWaitN
);

  AST_WE_INSIDE_CS: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCsN); // R4

  AST_WE_AFTER_CS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> $past(!memCsN)); // R4

  AST_CS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memCsN); // R6

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr)); // R6

  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    memWeN |-> (&memLaneN)); // R7

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && !memWaitN) |=> !memOeN); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    !memCsN |-> !reqReady); // R10

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> !memDataOe); // R11

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R11

endmodule

bind sram_wait_seq sram_wait_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
) u_chk (.*);

// File: tb/sram_wait_seq_test.sv
module sram_wait_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int WW = 4;
  localparam int LN = DW / 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic [LN-1:0] reqLanes = '0;
  logic [WW-1:0] cfgRdWait = '0;
  logic [WW-1:0] cfgWrWait = '0;
  logic          reqReady, done;
  logic [DW-1:0] rdData;
  logic          memCsN, memOeN, memWeN, memDataOe;
  logic [LN-1:0] memLaneN;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memDataOut;
  logic [DW-1:0] memDataIn = '0;
  logic          memWaitN = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sram_wait_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) uut (.*);

  typedef struct {
    bit            wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [LN-1:0] lanes;
    int            stbLen;
    string         tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int issued = 0;
  int seen = 0;
  int waitLen = 0;
  bit finished = 0;

  function automatic logic [DW-1:0] pattern(input logic [AW-1:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C5A;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Driver: pushes the expected item, then raises the request.
  task automatic runAccess(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic [LN-1:0] ln, input int rdw, input int wrw,
                           input int ww, input bit stress, input string tag);
    item_t it;
    int n;
    while (!reqReady) @(negedge clk);
    n = wr ? wrw : rdw;
    it.wr = wr; it.addr = a; it.wdata = d; it.lanes = ln;
    it.stbLen = ((n > ww) ? n : ww) + 1;
    it.tag = tag;
    q.push_back(it);
    issued++;
    cfgRdWait = WW'(rdw); cfgWrWait = WW'(wrw); waitLen = ww;
    reqWrite = wr; reqAddr = a; reqWdata = d; reqLanes = ln; reqValid = 1'b1;
    @(negedge clk);
    if (stress) begin
      reqWrite = ~wr; reqAddr = a ^ 16'hFFFF; reqWdata = ~d; reqLanes = ~ln;
      while (!done) @(negedge clk);
      reqValid = 1'b0;
    end else begin
      reqValid = 1'b0;
      while (!done) @(negedge clk);
    end
    @(negedge clk);
  endtask

  // Memory model and monitor, evaluated mid-cycle.
  int stbIdx = 0;
  bit active = 0;
  item_t cur;
  int csCnt, stb, pre, post;
  bit addrBad, laneBad, driveBad, idleBad;
  bit prevDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memOeN || !memWeN) begin
        memWaitN = (stbIdx >= waitLen);
        stbIdx++;
      end else begin
        memWaitN = 1'b1;
        stbIdx = 0;
      end
      memDataIn = !memOeN ? pattern(memAddr) : '0;

      check(!(done && prevDone), "R9", "done longer than one clock", 32'(done), 0);
      prevDone = done;

      if (!memCsN && !active) begin
        if (q.size() == 0) begin
          check(0, "R10", "access with no accepted request", 1, 0);
        end else begin
          cur = q.pop_front();
          active = 1;
          csCnt = 0; stb = 0; pre = 0; post = 0;
          addrBad = 0; laneBad = 0; driveBad = 0;
        end
      end
      if (active) begin
        if (!memCsN) begin
          csCnt++;
          if (cur.wr ? !memWeN : !memOeN) stb++;
          else if (stb == 0) pre++;
          else post++;
        end
        if (memAddr != cur.addr) addrBad = 1;
        if (!memWeN) begin
          if (memLaneN != ~cur.lanes) laneBad = 1;
        end else if (memLaneN != '1) laneBad = 1;
        if (memDataOe != (cur.wr && !memCsN)) driveBad = 1;
        if (memDataOe && memDataOut != cur.wdata) driveBad = 1;
        if (done) begin
          seen++;
          check(stb == cur.stbLen, cur.tag, "strobe length", 32'(stb), 32'(cur.stbLen));
          check(pre == (cur.wr ? 1 : 0), "R4", "cycles before strobe", 32'(pre), cur.wr ? 1 : 0);
          check(post == (cur.wr ? 1 : 0), cur.wr ? "R6" : "R2", "hold cycles with cs low",
                32'(post), cur.wr ? 1 : 0);
          check(!addrBad, "R6", "address held through access", 32'(addrBad), 0);
          check(!laneBad, "R7", "lane enables", 32'(laneBad), 0);
          check(!driveBad, "R11", "data drive window", 32'(driveBad), 0);
          if (!cur.wr)
            check(rdData == pattern(cur.addr), "R3", "captured read data",
                  32'(rdData), 32'(pattern(cur.addr)));
          active = 0;
        end
      end else begin
        if (memDataOe || memLaneN != '1 || !memOeN || !memWeN) idleBad = 1;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(0, "R1", "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    idleBad = 0;
    repeat (3) @(negedge clk);
    check(memCsN && memOeN && memWeN && (memLaneN == '1), "R1", "strobes in reset",
          {28'(0), memCsN, memOeN, memWeN, &memLaneN}, 32'hF);
    check(!memDataOe && !done && reqReady, "R1", "bus/done/ready in reset",
          {29'(0), memDataOe, done, reqReady}, 32'h1);
    rstN = 1'b1;
    @(negedge clk);

    runAccess(0, 16'h1234, '0, 2'b00, 0, 0, 0, 0, "R2");
    check(rdData == pattern(16'h1234), "R9", "rdData held after done",
          32'(rdData), 32'(pattern(16'h1234)));
    runAccess(0, 16'h0F0F, '0, 2'b00, 3, 0, 0, 0, "R3");
    runAccess(1, 16'h2000, 16'hBEEF, 2'b11, 0, 0, 0, 0, "R5");
    runAccess(1, 16'h2002, 16'hCAFE, 2'b01, 0, 2, 0, 0, "R5");
    runAccess(1, 16'h2004, 16'h5A5A, 2'b10, 0, 0, 0, 0, "R7");
    runAccess(0, 16'h4321, '0, 2'b00, 1, 0, 4, 0, "R8");
    runAccess(1, 16'h3000, 16'h1111, 2'b11, 0, 3, 2, 0, "R8");
    runAccess(1, 16'h3002, 16'h2222, 2'b01, 0, 0, 3, 0, "R8");
    runAccess(0, 16'hFFFE, '0, 2'b00, 15, 0, 0, 0, "R3");
    runAccess(0, 16'h7777, '0, 2'b00, 0, 0, 0, 1, "R10");
    runAccess(1, 16'h7778, 16'h9999, 2'b10, 0, 1, 0, 1, "R10");
    runAccess(0, 16'h0001, '0, 2'b00, 2, 0, 0, 0, "R3");

    repeat (6) @(negedge clk);
    check(q.size() == 0, "R10", "expected accesses left over", 32'(q.size()), 0);
    check(seen == issued, "R10", "completed accesses", 32'(seen), 32'(issued));
    check(!idleBad, "R11", "bus quiet while idle", 32'(idleBad), 0);
    summary();
  end

endmodule